// File: doc/BRIEF.md
# Odd/Even Byte-Bank Memory Controller

This block puts a byte-addressed memory space behind a 16-bit data bus. Storage is split into two independent byte-wide banks: one holds every even-addressed byte, the other every odd-addressed byte. A requester gives a 20-bit byte address, an active-low upper-byte enable, read and write strobes, and a 16-bit data path. The data path is modelled as separate write and read buses.

Address bit 0 and the upper-byte enable together pick the banks taking part in an access. Bits above bit 0 index the same location in both banks at once. The even bank always uses the lower byte lane and the odd bank always uses the upper byte lane, so no byte is ever shifted between lanes. An aligned 16-bit word moves in one cycle. The banks are kept shallow (parameter `BANK_AW` sets the index width), so address bits above the index do not take part in decoding.

Top module: `byte_bank_mem`

## Requirements
- R1: While `rst_ni` is low, every location of both banks is cleared to 0x00. After reset, a read of any address returns zero.
- R2: Address bits `BANK_AW`..1 index the same location in both banks. Address bits above `BANK_AW` (19..7 by default) have no effect, so an address that differs only in those bits reaches the same bytes.
- R3: With `addr_i[0]`=0 and `bhe_ni`=1, only the even bank is selected. A write stores `wdata_i[7:0]` and leaves the odd bank unchanged. A read returns the even byte on `rdata_o[7:0]` and 0x00 on `rdata_o[15:8]`.
- R4: With `addr_i[0]`=1 and `bhe_ni`=0, only the odd bank is selected. A write stores `wdata_i[15:8]` and leaves the even bank unchanged. A read returns the odd byte on `rdata_o[15:8]`, with bit 8 as its least significant bit, and 0x00 on `rdata_o[7:0]`.
- R5: With `addr_i[0]`=0 and `bhe_ni`=0, both banks are selected. A write stores a full 16-bit word in one cycle, the low byte to the even bank and the high byte to the odd bank. A read returns both bytes.
- R6: With `addr_i[0]`=1 and `bhe_ni`=1, no bank is selected. A write changes nothing, and a read returns 0x0000.
- R7: A write takes effect on the rising edge of `clk_i` while `wr_i` is 1. A read is combinational while `rd_i` is 1, and `rdata_o` is 0x0000 whenever `rd_i` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; writes happen on its rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset; clears both banks |
| addr_i | input | 20 | Byte address |
| bhe_ni | input | 1 | Active-low enable for the upper byte lane (odd bank) |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 16 | Write data; bits 7..0 go to the even bank, bits 15..8 to the odd bank |
| rdata_o | output | 16 | Read data; a lane whose bank is not selected is zero |

## Verification
Some properties are checked by assertions on every cycle:
- a written byte is present in its bank location on the next cycle;
- a bank location that is not written keeps its value;
- a lane whose bank is not selected reads as zero;
- the read bus is zero when no read is requested.

Other behaviours can only be shown by the bench's scenarios:
- the whole memory is cleared by reset;
- addresses that differ only in the unused upper bits reach the same bytes;
- one bank is written while the other keeps its old content;
- word data read back matches the word written.

These scenarios are compared against the bench's own byte-array model.

// File: rtl/bbm_pkg.sv
package bbm_pkg;
  localparam int ADDR_W = 20;
  localparam int BYTE_W = 8;
  localparam int LANES  = 2;
  localparam int DATA_W = BYTE_W * LANES;

  typedef enum logic [1:0] {
    ACC_NONE = 2'b00,
    ACC_EVEN = 2'b01,
    ACC_ODD  = 2'b10,
    ACC_WORD = 2'b11
  } acc_kind_e;
endpackage

// File: rtl/bbm_decode.sv
module bbm_decode
  import bbm_pkg::*;
(
  input  logic             a0_i,
  input  logic             bhe_ni,
  output logic [LANES-1:0] sel_o,
  output acc_kind_e        kind_o
);
  always_comb begin
    unique case ({a0_i, bhe_ni})
      2'b00:   kind_o = ACC_WORD;
      2'b01:   kind_o = ACC_EVEN;
      2'b10:   kind_o = ACC_ODD;
      default: kind_o = ACC_NONE;
    endcase
  end

  // bit 0 = even bank, bit 1 = odd bank
  assign sel_o = kind_o;
endmodule

// File: rtl/bbm_byte_bank.sv
module bbm_byte_bank #(
  parameter int IDX_W  = 6,
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              we_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << IDX_W;

  logic [BYTE_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[idx_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[idx_i];

  // R7: a write lands at the indexed location by the next cycle
  a_r7_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> mem_q[$past(idx_i)] == $past(wdata_i));

  // R6: a location that was not written keeps its content
  a_r6_hold_unwritten: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> mem_q[$past(idx_i)] == $past(rdata_o));
endmodule

// File: rtl/byte_bank_mem.sv
module byte_bank_mem
  import bbm_pkg::*;
#(
  parameter int BANK_AW = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              bhe_ni,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [LANES-1:0]   sel;
  acc_kind_e          kind;
  logic [BANK_AW-1:0] idx;

  assign idx = addr_i[BANK_AW:1];

  bbm_decode u_decode (
    .a0_i   (addr_i[0]),
    .bhe_ni (bhe_ni),
    .sel_o  (sel),
    .kind_o (kind)
  );

  for (genvar b = 0; b < LANES; b++) begin : g_bank
    logic [BYTE_W-1:0] bank_rd;

    bbm_byte_bank #(.IDX_W(BANK_AW), .BYTE_W(BYTE_W)) u_bank (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .idx_i   (idx),
      .we_i    (wr_i & sel[b]),
      .wdata_i (wdata_i[b*BYTE_W +: BYTE_W]),
      .rdata_o (bank_rd)
    );

    // fixed lane per bank: no shifting
    assign rdata_o[b*BYTE_W +: BYTE_W] = (rd_i && sel[b]) ? bank_rd : '0;
  end

  a_r7_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |-> rdata_o == '0);

  a_r3_upper_lane_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && bhe_ni) |-> rdata_o[DATA_W-1:BYTE_W] == '0);

  a_r4_lower_lane_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i[0]) |-> rdata_o[BYTE_W-1:0] == '0);

  a_r6_no_bank_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind == ACC_NONE) |-> rdata_o == '0);
endmodule

// File: tb/byte_bank_mem_tb.sv
module byte_bank_mem_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [19:0] addr_i = '0;
  logic        bhe_ni = 1'b1;
  logic        rd_i = 1'b0;
  logic        wr_i = 1'b0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  byte unsigned even_m [64];
  byte unsigned odd_m  [64];

  byte_bank_mem u_dut (.*);

  always #10 clk_i = ~clk_i;

  function automatic string tag_of(logic a0, logic bhe_n);
    case ({a0, bhe_n})
      2'b00:   return "R5";
      2'b01:   return "R3";
      2'b10:   return "R4";
      default: return "R6";
    endcase
  endfunction

  function automatic logic [15:0] model_read(logic [19:0] a, logic bhe_n, logic rd);
    logic [15:0] r = '0;
    int i = int'(a[6:1]);
    if (rd) begin
      if (!a[0])  r[7:0]  = even_m[i];
      if (!bhe_n) r[15:8] = odd_m[i];
    end
    return r;
  endfunction

  task automatic check(string req, logic [15:0] exp);
    n_chk++;
    if (rdata_o !== exp) begin
      n_fail++;
      $display("FAIL %s: rdata_o=%h expected %h", req, rdata_o, exp);
    end
  endtask

  task automatic clear_model();
    for (int i = 0; i < 64; i++) begin
      even_m[i] = 0;
      odd_m[i] = 0;
    end
  endtask

  // one bus cycle: drive after negedge, check mid-low-phase, update model at posedge
  task automatic bus(logic [19:0] a, logic bhe_n, logic rd, logic wr, logic [15:0] wd, string req = "");
    @(negedge clk_i);
    addr_i = a; bhe_ni = bhe_n; rd_i = rd; wr_i = wr; wdata_i = wd;
    #5;
    check(req == "" ? (rd ? tag_of(a[0], bhe_n) : "R7") : req, model_read(a, bhe_n, rd));
    @(posedge clk_i);
    if (wr) begin
      if (!a[0])  even_m[int'(a[6:1])] = wd[7:0];
      if (!bhe_n) odd_m[int'(a[6:1])]  = wd[15:8];
    end
  endtask

  initial begin
    clear_model();
    repeat (2) @(negedge clk_i);
    rd_i = 1'b1; bhe_ni = 1'b0; addr_i = 20'h00010;
    #5 check("R1", 16'h0000);
    @(negedge clk_i) rst_ni = 1'b1;

    bus(20'h00010, 1'b0, 1'b0, 1'b1, 16'hA55A, "R5");
    bus(20'h00010, 1'b0, 1'b1, 1'b0, 16'h0000, "R5");
    bus(20'h00010, 1'b1, 1'b1, 1'b0, 16'h0000, "R3");
    bus(20'h00011, 1'b0, 1'b1, 1'b0, 16'h0000, "R4");
    bus(20'h00011, 1'b0, 1'b0, 1'b1, 16'h77EE, "R4");
    bus(20'h00010, 1'b0, 1'b1, 1'b0, 16'h0000, "R4");
    bus(20'h00010, 1'b1, 1'b0, 1'b1, 16'h3C4D, "R3");
    bus(20'h00010, 1'b0, 1'b1, 1'b0, 16'h0000, "R3");
    bus(20'h00021, 1'b1, 1'b1, 1'b1, 16'hFFFF, "R6");
    bus(20'h00020, 1'b0, 1'b1, 1'b0, 16'h0000, "R6");
    bus(20'h00010, 1'b0, 1'b0, 1'b0, 16'h0000, "R7");
    bus(20'h80012, 1'b0, 1'b0, 1'b1, 16'hBEEF, "R2");
    bus(20'h00012, 1'b0, 1'b1, 1'b0, 16'h0000, "R2");
    bus(20'hFFF92, 1'b0, 1'b1, 1'b0, 16'h0000, "R2");

    for (int k = 0; k < 400; k++) begin
      logic [19:0] a = 20'($urandom);
      bus(a, 1'($urandom), 1'($urandom), 1'($urandom), 16'($urandom));
    end

    @(negedge clk_i);
    rst_ni = 1'b0; wr_i = 1'b0;
    clear_model();
    @(negedge clk_i) rst_ni = 1'b1;
    for (int i = 0; i < 64; i++) bus(20'(i * 2), 1'b0, 1'b1, 1'b0, 16'h0000, "R1");

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule